// File: doc/BRIEF.md
# Single-Channel Peripheral-to-Memory Transfer Engine

This block is one transfer channel that moves units of data between a fixed peripheral register and a RAM buffer whose address advances after every unit. Software sets it up through a small register port: an enable bit, the peripheral address, the starting RAM address, the unit count, and a mode word that holds the direction, the unit size (byte or 16-bit word) and which of the hardware trigger lines paces the transfers. A start bit then arms the channel.

Once armed, every accepted trigger, whether a software pulse or the selected hardware line, causes exactly one unit to move. The channel presents the transfer on a valid/ready request interface. `xfer_valid` asserts with the addresses, direction and size. The bus side accepts it by asserting `xfer_ready`, and the unit counts as moved on the rising clock edge where both are high. While `xfer_ready` stays low, the request and all of its fields stay unchanged, so the bus side may apply back-pressure for as long as it needs. The bus itself and the memory behind it are outside this block.

When the count runs out, the channel clears its start bit and pulses `done_irq` for one cycle. Clearing the enable bit stops the channel at once.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, `xfer_valid` and `done_irq` are 0 and every configuration register reads back 0.
- R2: The control register is selected by `cfg_sel`=0, with bit0 = enable, bit1 = start and bit2 = software trigger. While enable is 0, writes to the peripheral address (sel 1), RAM address (sel 2), count (sel 3) and mode (sel 4) registers are ignored, and no trigger produces a request.
- R3: Writing the control register with enable=1 and start=1 arms the channel. While start is 1, writes to selects 1 to 4 are ignored.
- R4: The mode register is laid out as bit0 = direction (1 = peripheral to RAM), bit1 = word size, bits 7:4 = hardware trigger select. A hardware trigger counts only when it arrives on `hw_trig[select]`. Pulses on the other lines have no effect.
- R5: Each trigger accepted while the channel is armed and has no request pending produces exactly one handshake. Triggers that arrive while the channel is unarmed or has a request outstanding are ignored.
- R6: While `xfer_valid` is 1 and `xfer_ready` is 0, `xfer_valid` and every `xfer_*` field hold their values, unless start is cleared.
- R7: After each handshake, the RAM address advances by 1 in byte mode or by 2 in word mode, modulo 2^16, and the count decreases by 1.
- R8: `xfer_periph_addr` stays equal to the programmed peripheral address for the whole sequence.
- R9: The handshake that brings the count to 0 clears start. `done_irq` is high for exactly the next cycle.
- R10: Writing enable=0 drops `xfer_valid` immediately after that edge and clears start.
- R11: The software trigger bit always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for writes |
| cfg_wdata | input | 16 | Write data |
| cfg_rsel | input | 3 | Register select for readback |
| cfg_rdata | output | 16 | Readback data (combinational) |
| hw_trig | input | 16 | Hardware trigger lines |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Transfer request accepted |
| xfer_periph_addr | output | 8 | Peripheral register address |
| xfer_ram_addr | output | 16 | Current RAM address |
| xfer_to_ram | output | 1 | 1 = peripheral to RAM, 0 = RAM to peripheral |
| xfer_word | output | 1 | 1 = 16-bit unit, 0 = byte |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The bound checker checks the following on every cycle:
- The request holds steady under back-pressure.
- The RAM address step and count decrement follow each handshake.
- The peripheral address stays fixed.
- `done_irq` is a single-cycle pulse that follows a handshake and leaves start cleared.
- A disabled channel never requests.

Only the bench scenarios can show the rest: trigger-line selection, triggers ignored while unarmed or while a request is pending, the write lockout while disabled or armed, the software-trigger readback, and that a whole sequence produces exactly the programmed number of handshakes with the right final address.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_REQ   = 2'd2
  } xfer_state_e;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_PADDR = 3'd1,
    SEL_RADDR = 3'd2,
    SEL_COUNT = 3'd3,
    SEL_MODE  = 3'd4
  } cfg_sel_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_START_BIT = 1;
  localparam int CTRL_SWTRG_BIT = 2;
  localparam int MODE_TSEL_LSB  = 4;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chan_pkg::*;
#(
  parameter int PA_W   = 8,
  parameter int RA_W   = 16,
  parameter int CNT_W  = 16,
  parameter int TSEL_W = 4,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic [2:0]        cfg_rsel,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              step,
  input  logic              done,
  output logic              en,
  output logic              start,
  output logic              sw_trig,
  output logic [PA_W-1:0]   paddr,
  output logic [RA_W-1:0]   raddr,
  output logic [CNT_W-1:0]  count,
  output logic              dir_to_ram,
  output logic              word,
  output logic [TSEL_W-1:0] tsel,
  output logic              count_last
);
  logic ctrl_wr;
  logic cfg_open;

  assign ctrl_wr    = cfg_we && (cfg_sel == SEL_CTRL);
  assign cfg_open   = en && !start;
  assign sw_trig    = ctrl_wr && cfg_wdata[CTRL_SWTRG_BIT];
  assign count_last = (count == CNT_W'(1));

  // Control: the completion clears start even against a concurrent write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      start <= 1'b0;
    end else if (ctrl_wr) begin
      en    <= cfg_wdata[CTRL_EN_BIT];
      start <= cfg_wdata[CTRL_EN_BIT] && cfg_wdata[CTRL_START_BIT] && !done;
    end else if (done) begin
      start <= 1'b0;
    end
  end

  // Setup registers: writable only while enabled and not armed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr      <= '0;
      raddr      <= '0;
      count      <= '0;
      dir_to_ram <= 1'b0;
      word       <= 1'b0;
      tsel       <= '0;
    end else if (step) begin
      raddr <= raddr + (word ? RA_W'(2) : RA_W'(1));
      count <= count - CNT_W'(1);
    end else if (cfg_we && cfg_open) begin
      case (cfg_sel)
        SEL_PADDR: paddr <= cfg_wdata[PA_W-1:0];
        SEL_RADDR: raddr <= cfg_wdata[RA_W-1:0];
        SEL_COUNT: count <= cfg_wdata[CNT_W-1:0];
        SEL_MODE: begin
          dir_to_ram <= cfg_wdata[0];
          word       <= cfg_wdata[1];
          tsel       <= cfg_wdata[MODE_TSEL_LSB +: TSEL_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_rsel)
      SEL_CTRL:  cfg_rdata = DW'({start, en});
      SEL_PADDR: cfg_rdata = DW'(paddr);
      SEL_RADDR: cfg_rdata = DW'(raddr);
      SEL_COUNT: cfg_rdata = DW'(count);
      SEL_MODE:  cfg_rdata = DW'({tsel, 2'b00, word, dir_to_ram});
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_trig_sel.sv
module dma_trig_sel #(
  parameter int NTRIG  = 16,
  parameter int TSEL_W = 4
) (
  input  logic [NTRIG-1:0]  hw_trig,
  input  logic [TSEL_W-1:0] tsel,
  input  logic              sw_trig,
  output logic              trig
);
  logic [NTRIG-1:0] hit;

  for (genvar i = 0; i < NTRIG; i++) begin : g_line
    assign hit[i] = hw_trig[i] && (tsel == TSEL_W'(i));
  end

  assign trig = sw_trig || (|hit);
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic trig,
  input  logic ack,
  input  logic count_last,
  output logic req,
  output logic step,
  output logic done,
  output logic done_irq
);
  xfer_state_e state_q, state_d;

  assign req  = (state_q == ST_REQ) && start && en;
  assign step = req && ack;
  assign done = step && count_last;

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (start) state_d = ST_ARMED;
        ST_ARMED: begin
          if (!start)    state_d = ST_IDLE;
          else if (trig) state_d = ST_REQ;
        end
        ST_REQ: begin
          if (!start)   state_d = ST_IDLE;
          else if (ack) state_d = count_last ? ST_IDLE : ST_ARMED;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done_irq <= 1'b0;
    end else begin
      state_q  <= state_d;
      done_irq <= done;
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int PA_W  = 8,
  parameter int RA_W  = 16,
  parameter int CNT_W = 16,
  parameter int NTRIG = 16,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [2:0]       cfg_rsel,
  output logic [DW-1:0]    cfg_rdata,
  input  logic [NTRIG-1:0] hw_trig,
  output logic             xfer_valid,
  input  logic             xfer_ready,
  output logic [PA_W-1:0]  xfer_periph_addr,
  output logic [RA_W-1:0]  xfer_ram_addr,
  output logic             xfer_to_ram,
  output logic             xfer_word,
  output logic             done_irq
);
  localparam int TSEL_W = $clog2(NTRIG);

  logic              cfg_en, cfg_start, sw_trig, count_last;
  logic              step, done, trig;
  logic [CNT_W-1:0]  cfg_count;
  logic [TSEL_W-1:0] tsel;

  dma_cfg_regs #(
    .PA_W(PA_W), .RA_W(RA_W), .CNT_W(CNT_W), .TSEL_W(TSEL_W), .DW(DW)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .cfg_rsel   (cfg_rsel),
    .cfg_rdata  (cfg_rdata),
    .step       (step),
    .done       (done),
    .en         (cfg_en),
    .start      (cfg_start),
    .sw_trig    (sw_trig),
    .paddr      (xfer_periph_addr),
    .raddr      (xfer_ram_addr),
    .count      (cfg_count),
    .dir_to_ram (xfer_to_ram),
    .word       (xfer_word),
    .tsel       (tsel),
    .count_last (count_last)
  );

  dma_trig_sel #(.NTRIG(NTRIG), .TSEL_W(TSEL_W)) u_trig (
    .hw_trig (hw_trig),
    .tsel    (tsel),
    .sw_trig (sw_trig),
    .trig    (trig)
  );

  dma_xfer_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cfg_en),
    .start      (cfg_start),
    .trig       (trig),
    .ack        (xfer_ready),
    .count_last (count_last),
    .req        (xfer_valid),
    .step       (step),
    .done       (done),
    .done_irq   (done_irq)
  );
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int PA_W  = 8,
  parameter int RA_W  = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic [PA_W-1:0]  xfer_periph_addr,
  input logic [RA_W-1:0]  xfer_ram_addr,
  input logic             xfer_to_ram,
  input logic             xfer_word,
  input logic             done_irq,
  input logic             en,
  input logic             start,
  input logic [CNT_W-1:0] count
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid || !start));

  // R6
  req_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> ($stable(xfer_ram_addr) && $stable(xfer_periph_addr)
                                     && $stable(xfer_word) && $stable(xfer_to_ram)));

  // R7
  ram_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=>
      (xfer_ram_addr == $past(xfer_ram_addr) + ($past(xfer_word) ? RA_W'(2) : RA_W'(1))));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> (count == $past(count) - CNT_W'(1)));

  // R8
  periph_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> $stable(xfer_periph_addr));

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R9
  irq_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> ($past(xfer_valid && xfer_ready) && !start));

  // R10
  no_req_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !xfer_valid);
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.PA_W(PA_W), .RA_W(RA_W), .CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .xfer_valid       (xfer_valid),
  .xfer_ready       (xfer_ready),
  .xfer_periph_addr (xfer_periph_addr),
  .xfer_ram_addr    (xfer_ram_addr),
  .xfer_to_ram      (xfer_to_ram),
  .xfer_word        (xfer_word),
  .done_irq         (done_irq),
  .en               (cfg_en),
  .start            (cfg_start),
  .count            (cfg_count)
);

// File: tb/tb_dma_chan_ctrl.sv
`timescale 1ns/1ps
module tb_dma_chan_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [2:0]  cfg_rsel = '0;
  logic [15:0] cfg_rdata;
  logic [15:0] hw_trig = '0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [7:0]  xfer_periph_addr;
  logic [15:0] xfer_ram_addr;
  logic        xfer_to_ram, xfer_word, done_irq;

  int n_cmp = 0, n_bad = 0, hs_cnt = 0, irq_cnt = 0;
  logic [7:0]  exp_pa = '0;
  logic [15:0] exp_ra = '0;
  logic        exp_word = 1'b0, exp_dir = 1'b0, prev_hs = 1'b0;

  always #4 clk = ~clk;

  dma_chan_ctrl dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] final_ra(logic [15:0] ra, int n, logic w);
    return ra + 16'(n * (w ? 2 : 1));
  endfunction

  // Monitor samples between the drive point and the next rising edge.
  always begin
    @(negedge clk); #2;
    if (done_irq) check("R9 irq follows final handshake", 32'(prev_hs), 32'd1);
    if (done_irq) irq_cnt++;
    prev_hs = xfer_valid && xfer_ready;
    if (xfer_valid && xfer_ready) begin
      hs_cnt++;
      check("R8 periph addr", 32'(xfer_periph_addr), 32'(exp_pa));
      check("R7 ram addr", 32'(xfer_ram_addr), 32'(exp_ra));
      check("R6 fields word/dir", 32'({xfer_word, xfer_to_ram}), 32'({exp_word, exp_dir}));
      exp_ra = exp_ra + (exp_word ? 16'd2 : 16'd1);
    end
  end

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [15:0] v);
    cfg_rsel = s; #1; v = cfg_rdata;
  endtask

  task automatic pulse_hw(input int idx);
    @(negedge clk); hw_trig = 16'd1 << idx;
    @(negedge clk); hw_trig = '0;
  endtask

  task automatic idle_check(input string tag);
    repeat (3) @(negedge clk);
    check(tag, 32'(xfer_valid), 32'd0);
  endtask

  task automatic serve();
    int k = 0;
    while (!xfer_valid && k < 20) begin @(negedge clk); k++; end
    check("R5 trigger gives request", 32'(xfer_valid), 32'd1);
    repeat ($urandom % 4) begin
      @(negedge clk);
      check("R6 valid held under back-pressure", 32'(xfer_valid), 32'd1);
    end
    xfer_ready = 1'b1;
    @(negedge clk); xfer_ready = 1'b0;
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 valid after reset", 32'(xfer_valid), 32'd0);
    check("R1 irq after reset", 32'(done_irq), 32'd0);
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v);
      check("R1 register reset value", 32'(v), 32'd0);
    end

    // R2 disabled: writes ignored, triggers ignored
    wr(3'd1, 16'h005A);
    wr(3'd3, 16'd4);
    rd(3'd1, v); check("R2 paddr write ignored while disabled", 32'(v), 32'd0);
    rd(3'd3, v); check("R2 count write ignored while disabled", 32'(v), 32'd0);
    @(negedge clk); hw_trig = 16'hFFFF; @(negedge clk); hw_trig = '0;
    wr(3'd0, 16'h0004);
    idle_check("R2 no request while disabled");

    // R5 / R11 enabled but not armed
    wr(3'd0, 16'h0001);
    wr(3'd4, 16'h0030);
    pulse_hw(3);
    wr(3'd0, 16'h0005);
    idle_check("R5 trigger ignored while unarmed");
    rd(3'd0, v); check("R11 soft trigger reads zero", 32'(v), 32'd1);

    // R3 lockout while armed
    wr(3'd3, 16'd2); wr(3'd2, 16'h0100); wr(3'd1, 16'h0033);
    wr(3'd0, 16'h0003);
    wr(3'd2, 16'h0200); wr(3'd4, 16'h0050);
    rd(3'd2, v); check("R3 raddr write ignored while armed", 32'(v), 32'h0100);
    rd(3'd4, v); check("R3 mode write ignored while armed", 32'(v), 32'h0030);
    rd(3'd0, v); check("R3 armed control readback", 32'(v), 32'd3);

    // R10 disable during outstanding request
    exp_pa = 8'h33; exp_ra = 16'h0100; exp_word = 1'b0; exp_dir = 1'b0;
    pulse_hw(3);
    @(negedge clk);
    check("R10 request raised before disable", 32'(xfer_valid), 32'd1);
    wr(3'd0, 16'h0000);
    check("R10 request dropped on disable", 32'(xfer_valid), 32'd0);
    rd(3'd0, v); check("R10 start cleared on disable", 32'(v), 32'd0);
    check("R10 no handshake happened", 32'(hs_cnt), 32'd0);

    // Random sequences
    for (int i = 0; i < 24; i++) begin
      logic [7:0]  pa;
      logic [15:0] ra;
      logic        w, d;
      int          n, ts, hs0, irq0;
      pa = 8'($urandom); ra = 16'($urandom);
      w = 1'($urandom); d = 1'($urandom);
      n = 1 + int'($urandom % 5); ts = int'($urandom % 16);
      if (i == 0) begin ra = 16'hFFFF; w = 1'b1; n = 3; end
      if (i == 1) begin ra = 16'hFFFE; w = 1'b0; n = 4; end
      wr(3'd0, 16'h0001);
      wr(3'd1, 16'(pa)); wr(3'd2, ra); wr(3'd3, 16'(n));
      wr(3'd4, {8'h00, 4'(ts), 2'b00, w, d});
      exp_pa = pa; exp_ra = ra; exp_word = w; exp_dir = d;
      hs0 = hs_cnt; irq0 = irq_cnt;
      wr(3'd0, 16'h0003);
      @(negedge clk);
      for (int j = 0; j < n; j++) begin
        if ($urandom % 3 == 0) begin
          pulse_hw((ts + 1 + int'($urandom % 15)) % 16);
          idle_check("R4 unselected line ignored");
        end
        if ($urandom % 2 == 0) wr(3'd0, 16'h0007);
        else pulse_hw(ts);
        if ($urandom % 3 == 0) begin
          @(negedge clk);
          pulse_hw(ts);
        end
        serve();
      end
      repeat (3) @(negedge clk);
      check("R5 one handshake per trigger", 32'(hs_cnt - hs0), 32'(n));
      check("R9 one completion pulse", 32'(irq_cnt - irq0), 32'd1);
      check("R9 no request after completion", 32'(xfer_valid), 32'd0);
      rd(3'd0, v); check("R9 start cleared at completion", 32'(v), 32'd1);
      rd(3'd3, v); check("R7 count reaches zero", 32'(v), 32'd0);
      rd(3'd2, v); check("R7 final ram addr", 32'(v), 32'(final_ra(ra, n, w)));
      rd(3'd1, v); check("R8 periph addr unchanged", 32'(v), 32'(pa));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule